// File: doc/BRIEF.md
# Maintenance panel code display driver

This block writes a status number onto a small external decimal display that has no parallel load path. The display has only three control lines: an increment line, a zero control and a visibility control. To show a number, the block first zeroes and blanks the display. It then produces one increment pulse for every unit of the number. Every control value stays on the lines for a parameterised minimum number of clocks, so the external counter always sees clean edges.

A requester presents the code plus one on `code_p1_i` and strobes `start_i`. Two kinds of request exist. A normal request ends with a one-cycle `done_o`, after which the block is free for the next code. A fatal request does not complete. After the last pulse the block hides the display and then keeps switching its visibility on and off with a long self-timed delay. The blinking goes on until reset. The codes a system would use are known ahead of time: CPU faults in the low nineties, bank counts just above one hundred, bus and memory faults in the one-fifties and one-sixties, image-copy progress and checksum results at 170 and 171, and 899 for "about to start". They are carried as plain binary values of `CODE_W` bits.

Top module: `panel_code_drv`

## Requirements
- R1: After reset `ctrl_o` is 7, `done_o` is 0 and `fatal_o` is 0. Control encoding: bit 2 is the increment line level, bit 1 is the run bit (0 zeroes the display), and bit 0 is the visibility bit (1 shows the display).
- R2: A start accepted in idle drives `ctrl_o` to 4 (zero, blank, increment high) from the next cycle. The value 4 is held for exactly `HOLD_CYC` cycles.
- R3: A request with `code_p1_i` = N produces max(N-1, 0) increment pulses. Each pulse is `ctrl_o` = 3 for `HOLD_CYC` cycles followed by `ctrl_o` = 7 for `HOLD_CYC` cycles. A value of 0 gives no pulses.
- R4: A normal request raises `done_o` for exactly one cycle, in the cycle after its last control phase ends. During that cycle `ctrl_o` is 7.
- R5: `start_i` has no effect while a sequence is in progress. Neither `ctrl_o` nor `fatal_o` changes because of it.
- R6: A start raised in the cycle where `done_o` is high is accepted, and a new sequence begins on the next cycle.
- R7: A request with `fatal_i` set drives `fatal_o` to 1 from the cycle after acceptance. It never raises `done_o`. After its pulses it drives `ctrl_o` to 6 after one `HOLD_CYC` phase.
- R8: In the fatal state, bit 0 of `ctrl_o` is inverted once every `OUTER` × 2^`INNER_W` cycles, indefinitely. `ctrl_o` bits 2 and 1 stay at 1.
- R9: `fatal_o` stays 1 and further starts are ignored until `rst_ni` is asserted. Reset returns all outputs to the R1 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled in idle |
| fatal_i | input | 1 | Request is fatal (blink after writing) |
| code_p1_i | input | CODE_W | Code to display plus one |
| done_o | output | 1 | One-cycle completion pulse for a normal request |
| fatal_o | output | 1 | Sticky fatal flag |
| ctrl_o | output | 3 | External display control lines |

## Verification
The completion pulse and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising `start_i` in the cycle in which it observes `done_o`. It then requires three things: the second clear phase starts on the next cycle, the value 7 before it lasted `HOLD_CYC`+1 cycles, and each request gets exactly one `done_o` at its computed cycle. The bench also strobes a fatal request in the middle of a busy sequence. It judges that strobe through `fatal_o` and through the unchanged `ctrl_o` transition stream.

// File: rtl/panel_pkg.sv
package panel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_LO,
    ST_HI,
    ST_BLINK
  } st_e;

  // bit2 increment level, bit1 run (0 = zero), bit0 visible
  localparam logic [2:0] CTRL_CLEAR = 3'd4;
  localparam logic [2:0] CTRL_LOW   = 3'd3;
  localparam logic [2:0] CTRL_HIGH  = 3'd7;
  localparam logic [2:0] CTRL_PARK  = 3'd6;
endpackage

// File: rtl/panel_hold_timer.sv
module panel_hold_timer #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expire_o
);
  localparam int W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= W'(HOLD_CYC - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

  a_r2_hold_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/panel_pulse_cnt.sv
module panel_pulse_cnt #(
  parameter int CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_p1_i,
  input  logic              dec_i,
  output logic              zero_o
);
  logic [CODE_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= '0;
    else if (load_i)
      rem_q <= (code_p1_i == '0) ? '0 : code_p1_i - CODE_W'(1);
    else if (dec_i)
      rem_q <= rem_q - CODE_W'(1);
  end

  assign zero_o = (rem_q == '0);

  a_r3_dec_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);
endmodule

// File: rtl/panel_blink_timer.sv
module panel_blink_timer #(
  parameter int OUTER   = 12,
  parameter int INNER_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int OW = (OUTER > 1) ? $clog2(OUTER) : 1;

  logic [INNER_W-1:0] inner_q;
  logic [OW-1:0]      outer_q;
  logic               inner_wrap, last;

  assign inner_wrap = &inner_q;
  assign last       = inner_wrap && (outer_q == OW'(OUTER - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inner_q <= '0;
      outer_q <= '0;
    end else if (!en_i) begin
      inner_q <= '0;
      outer_q <= '0;
    end else begin
      inner_q <= inner_q + 1'b1;
      if (inner_wrap) outer_q <= last ? '0 : outer_q + 1'b1;
    end
  end

  assign tick_o = en_i && last;

  a_r8_outer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(outer_q) < OUTER);
endmodule

// File: rtl/panel_code_drv.sv
module panel_code_drv
  import panel_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int HOLD_CYC = 4,
  parameter int OUTER    = 12,
  parameter int INNER_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fatal_i,
  input  logic [CODE_W-1:0] code_p1_i,
  output logic              done_o,
  output logic              fatal_o,
  output logic [2:0]        ctrl_o
);
  st_e        state_q, state_d;
  logic [2:0] ctrl_q, ctrl_d;
  logic       done_q, done_d;
  logic       fatal_q, fatal_d;
  logic       hold_load, hold_exp;
  logic       cnt_load, cnt_dec, cnt_zero;
  logic       blink_tick;

  panel_hold_timer #(.HOLD_CYC(HOLD_CYC)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (hold_load),
    .expire_o (hold_exp)
  );

  panel_pulse_cnt #(.CODE_W(CODE_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cnt_load),
    .code_p1_i (code_p1_i),
    .dec_i     (cnt_dec),
    .zero_o    (cnt_zero)
  );

  panel_blink_timer #(.OUTER(OUTER), .INNER_W(INNER_W)) i_blink (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_BLINK),
    .tick_o (blink_tick)
  );

  always_comb begin
    state_d   = state_q;
    ctrl_d    = ctrl_q;
    done_d    = 1'b0;
    fatal_d   = fatal_q;
    hold_load = 1'b0;
    cnt_load  = 1'b0;
    cnt_dec   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d   = ST_CLR;
        ctrl_d    = CTRL_CLEAR;
        hold_load = 1'b1;
        cnt_load  = 1'b1;
        fatal_d   = fatal_i;
      end
      ST_CLR, ST_HI: if (hold_exp) begin
        if (!cnt_zero) begin
          cnt_dec   = 1'b1;
          state_d   = ST_LO;
          ctrl_d    = CTRL_LOW;
          hold_load = 1'b1;
        end else if (fatal_q) begin
          state_d = ST_BLINK;
          ctrl_d  = CTRL_PARK;
        end else begin
          state_d = ST_IDLE;
          ctrl_d  = CTRL_HIGH;
          done_d  = 1'b1;
        end
      end
      ST_LO: if (hold_exp) begin
        state_d   = ST_HI;
        ctrl_d    = CTRL_HIGH;
        hold_load = 1'b1;
      end
      ST_BLINK: if (blink_tick) ctrl_d = ctrl_q ^ 3'b001;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ctrl_q  <= CTRL_HIGH;
      done_q  <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      done_q  <= done_d;
      fatal_q <= fatal_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign done_o  = done_q;
  assign fatal_o = fatal_q;

  a_r2_clear_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLR) |-> (ctrl_o == CTRL_CLEAR));
  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ctrl_o == CTRL_HIGH && state_q == ST_IDLE));
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_no_done_fatal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> !done_o);
  a_r9_fatal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
  a_r8_blink_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BLINK) |-> (ctrl_o[2:1] == 2'b11));
endmodule

// File: tb/test_panel_code_drv.sv
module test_panel_code_drv;
  localparam int CLK_P = 10;
  localparam int H     = 3;
  localparam int OUT   = 3;
  localparam int IW    = 3;
  localparam int D     = OUT * (1 << IW);
  localparam int CW    = 10;

  typedef struct {
    logic [2:0] val;
    int         len;
    string      tag;
  } item_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          fatal_i = 1'b0;
  logic [CW-1:0] code_p1_i = '0;
  logic          done_o, fatal_o;
  logic [2:0]    ctrl_o;

  int n_chk = 0, n_fail = 0;
  item_t exp_q[$];
  int    done_exp_q[$];
  int    cyc = 0, seg_start = 0, t4 = 0, done_cnt = 0;
  logic  [2:0] prev_ctrl = 3'd7;
  logic  done_prev = 1'b0;
  bit    mon_en = 1'b0;
  item_t it;
  int    dn;

  panel_code_drv #(.CODE_W(CW), .HOLD_CYC(H), .OUTER(OUT), .INNER_W(IW)) i_panel_code_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .fatal_i(fatal_i),
    .code_p1_i(code_p1_i), .done_o(done_o), .fatal_o(fatal_o), .ctrl_o(ctrl_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic void push(input logic [2:0] v, input int len, input string tag);
    item_t x;
    x.val = v; x.len = len; x.tag = tag;
    exp_q.push_back(x);
  endfunction

  // Driver: queue the expected control stream, then strobe.
  task automatic send(input int p1, input bit fat, input int first_len);
    int n = (p1 == 0) ? 0 : p1 - 1;
    push(3'd4, first_len, "R2 clear");
    for (int i = 0; i < n; i++) begin
      push(3'd3, H, "R3 low");
      push(3'd7, H, "R3 high");
    end
    if (fat) begin
      push(3'd6, H, "R7 park");
      push(3'd7, D, "R8 blink");
      push(3'd6, D, "R8 blink");
      push(3'd7, D, "R8 blink");
    end else begin
      if (n == 0) push(3'd7, H, "R3 zero pulses");
      done_exp_q.push_back(n);
    end
    start_i   = 1'b1;
    fatal_i   = fat;
    code_p1_i = CW'(p1);
    @(negedge clk_i);
    start_i = 1'b0;
    fatal_i = 1'b0;
  endtask

  task automatic poke(input int p1);
    start_i = 1'b1; fatal_i = 1'b1; code_p1_i = CW'(p1);
    @(negedge clk_i);
    start_i = 1'b0; fatal_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk_i);
  endtask

  // Monitor / scoreboard
  always @(negedge clk_i) begin
    cyc++;
    if (mon_en) begin
      if (ctrl_o !== prev_ctrl) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected ctrl change", int'(ctrl_o), int'(prev_ctrl));
        else begin
          it = exp_q.pop_front();
          chk(ctrl_o == it.val, it.tag, int'(ctrl_o), int'(it.val));
          if (it.len != 0) chk(cyc - seg_start == it.len, {it.tag, " hold length"}, cyc - seg_start, it.len);
        end
        if (ctrl_o == 3'd4) t4 = cyc;
        prev_ctrl = ctrl_o;
        seg_start = cyc;
      end
      if (done_o) begin
        done_cnt++;
        if (done_prev) chk(1'b0, "R4 done wider than one cycle", 2, 1);
        if (done_exp_q.size() == 0) chk(1'b0, "R4 unexpected done", 1, 0);
        else begin
          dn = done_exp_q.pop_front();
          chk(cyc == t4 + H + 2*dn*H, "R4 done timing", cyc, t4 + H + 2*dn*H);
        end
      end
      done_prev = done_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(ctrl_o == 3'd7, "R1 reset ctrl", int'(ctrl_o), 7);
    chk(!done_o, "R1 reset done", int'(done_o), 0);
    chk(!fatal_o, "R1 reset fatal", int'(fatal_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    prev_ctrl = ctrl_o; seg_start = cyc; mon_en = 1'b1;

    send(1, 1'b0, 0);            // code 0
    wait_done(); @(negedge clk_i);
    send(0, 1'b0, 0);            // R3 saturating zero
    wait_done(); @(negedge clk_i);
    send(4, 1'b0, 0);            // three pulses, R5 poke mid-run
    repeat (4) @(negedge clk_i);
    poke(9);
    chk(!fatal_o, "R5 fatal unaffected by busy start", int'(fatal_o), 0);
    wait_done();
    // R6: start in the done cycle
    send(3, 1'b0, H + 1);
    wait_done(); @(negedge clk_i);
    chk(done_cnt == 4, "R4 done count", done_cnt, 4);
    chk(exp_q.size() == 0, "R3 all transitions seen", exp_q.size(), 0);

    repeat (2) @(negedge clk_i);
    send(3, 1'b1, 0);
    chk(fatal_o, "R7 fatal flag set", int'(fatal_o), 1);
    repeat (H + 4*H + D + 4) @(negedge clk_i);
    poke(2);
    repeat (2*D - 4) @(negedge clk_i);
    chk(fatal_o, "R9 fatal sticky", int'(fatal_o), 1);
    chk(done_cnt == 4, "R7 no done on fatal", done_cnt, 4);
    chk(exp_q.size() == 0, "R8 three toggles seen", exp_q.size(), 0);

    mon_en = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(!fatal_o, "R9 reset clears fatal", int'(fatal_o), 0);
    chk(ctrl_o == 3'd7, "R9 reset ctrl", int'(ctrl_o), 7);
    rst_ni = 1'b1;
    exp_q.delete(); done_exp_q.delete();
    @(negedge clk_i);
    prev_ctrl = ctrl_o; seg_start = cyc; done_prev = 1'b0; mon_en = 1'b1;
    send(6, 1'b0, 0);
    wait_done(); @(negedge clk_i);
    chk(done_cnt == 5, "R9 normal after reset", done_cnt, 5);
    chk(exp_q.size() == 0, "R3 stream after reset", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule